// File: doc/BRIEF.md
# Variable-Reach Address Translation Buffer

This block is a small, fully associative translation buffer that turns a virtual address into a physical address. Each entry holds one mapping, and its two-bit granularity hint sets how far that mapping reaches. At the smallest setting an entry covers a single 8 KB base page. The larger settings cover an aligned run of 8, 64 or 512 contiguous base pages, up to 4 MB. The hint sets the compare mask of each entry and its address merge on its own, so short-reach and long-reach mappings sit side by side in one associative array.

A lookup is presented on the lookup port and its result arrives one clock later. A fill writes a new mapping: it goes into the lowest-numbered free entry, or into a round-robin victim when no entry is free. A single invalidate pin empties the array. A superpage pin bypasses the array and maps the virtual address straight onto the physical space, modulo its size.

A build-time option splits the array into two regions. One region accepts only single base pages and the other accepts only 4 MB groups. Page walking and miss handling stay outside the block.

The lookup port has no back-pressure: a request presented with `lk_valid` is always accepted, and the response must be consumed in the cycle it appears. The fill port is valid/ready. A fill is taken in the cycle where both `fill_valid` and `fill_ready` are high. `fill_ready` drops only while `inval_all` is high, so a fill offered in that cycle stays pending with its source.

Top module: `vtlb`

## Requirements
- R1: After reset no entry is valid. Every response output is zero, and a lookup without superpage mode reports a miss.
- R2: Virtual address bits [12:0] always appear unchanged as physical bits [12:0]. With hint 0, all virtual page number bits (VA[31:13]) must equal the stored tag for a match.
- R3: A hint value n (0, 1, 2, 3) maps 1, 8, 64 or 512 base pages. The low 3n virtual page number bits are left out of the compare, and the same bits are copied from the virtual address into the physical frame number.
- R4: A fill stores both the tag and the frame number with their low 3n bits forced to zero. Low bits given on the fill port therefore do not change the translation.
- R5: The response to a lookup is due one clock after `lk_valid`. `rsp_valid` repeats `lk_valid` one cycle late. When `lk_valid` was low, `rsp_hit`, `rsp_fault`, `rsp_pa` and `rsp_prot` are zero. A fill becomes visible to lookups from the next cycle on.
- R6: A read (`lk_write`=0) needs the read permission and a write (`lk_write`=1) needs the write permission. A match without that permission gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_pa`=0. `rsp_prot` shows {write, read} of the matched entry on a hit or a fault, and is 0 otherwise.
- R7: A fill goes to the lowest-numbered invalid entry. When every entry is valid, it replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and moves up by one, wrapping, at each such replacement. When several entries match, the lowest-numbered one answers.
- R8: `inval_all` clears every entry in one cycle. A lookup in that cycle misses, `fill_ready` is low in that cycle, and no fill is stored.
- R9: In superpage mode (`sp_mode`=1) a lookup always hits, with `rsp_pa` = VA modulo 2^PA_W and `rsp_prot`=2'b11. No entry is used, and `inval_all` does not affect the result.
- R10: With SPLIT=1 the first SMALL_N entries hold only single base pages and the last LARGE_N entries hold only 4 MB groups. A fill with hint 0 goes to the small region. Any other hint goes to the large region and is stored as hint 3. Each region has its own round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_all | input | 1 | Clear all entries this cycle |
| sp_mode | input | 1 | Superpage direct mapping for lookups |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | 1 for a write access, 0 for a read access |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill accepted when high together with fill_valid |
| fill_vpn | input | VA_W-13 | Virtual page number of the new mapping |
| fill_pfn | input | PA_W-13 | Physical frame number of the new mapping |
| fill_hint | input | 2 | Granularity hint (pages = 8^hint) |
| fill_rd | input | 1 | Read permission of the new mapping |
| fill_wr | input | 1 | Write permission of the new mapping |
| rsp_valid | output | 1 | Response present (lookup of the previous cycle) |
| rsp_hit | output | 1 | Translation found with permission |
| rsp_fault | output | 1 | Translation found but permission missing |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_prot | output | 2 | {write, read} permission of the answering entry |

## Verification
Each lookup result is due exactly one rising edge after the request, and a fill or an invalidate changes the answer only for lookups presented in a later cycle. `fill_ready` reacts in the same cycle as `inval_all`. The bench drives every input on the falling edge and compares all five response outputs on the next falling edge against a behavioural model updated in the same step. Because of this, each comparison sees exactly one register stage of latency. The split configuration is checked on a second instance with directed lookups sampled with the same one-edge delay.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int OFS_W   = 13;
  localparam int GH_STEP = 3;

  typedef enum logic [1:0] {
    GH_X1   = 2'd0,
    GH_X8   = 2'd1,
    GH_X64  = 2'd2,
    GH_X512 = 2'd3
  } gh_e;

  // number of low page-number bits a hint removes from the compare
  function automatic int unsigned gh_low_bits(input logic [1:0] gh);
    return GH_STEP * int'(gh);
  endfunction
endpackage

// File: rtl/vtlb_slot.sv
module vtlb_slot import vtlb_pkg::*; #(
  parameter int         VPN_W    = 19,
  parameter int         PFN_W    = 17,
  parameter bit         PIN_HINT = 1'b0,
  parameter logic [1:0] PIN_VAL  = 2'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inval,
  input  logic             load,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [PFN_W-1:0] ld_pfn,
  input  logic [1:0]       ld_hint,
  input  logic             ld_rd,
  input  logic             ld_wr,
  input  logic [VPN_W-1:0] q_vpn,
  output logic             valid,
  output logic             match,
  output logic [PFN_W-1:0] q_pfn,
  output logic             rd_ok,
  output logic             wr_ok
);
  logic             valid_q;
  logic [VPN_W-1:0] tag_q;
  logic [PFN_W-1:0] pfn_q;
  logic [1:0]       hint_q;
  logic             rd_q, wr_q;

  logic [1:0]       hint_in;
  logic [VPN_W-1:0] in_mask, cur_mask;
  logic [PFN_W-1:0] in_pmask;

  assign hint_in  = PIN_HINT ? PIN_VAL : ld_hint;
  assign in_mask  = (VPN_W'(1) << gh_low_bits(hint_in)) - VPN_W'(1);
  assign in_pmask = (PFN_W'(1) << gh_low_bits(hint_in)) - PFN_W'(1);
  assign cur_mask = (VPN_W'(1) << gh_low_bits(hint_q)) - VPN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)      valid_q <= 1'b0;
    else if (inval)  valid_q <= 1'b0;
    else if (load)   valid_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (load && !inval) begin
      tag_q  <= ld_vpn & ~in_mask;
      pfn_q  <= ld_pfn & ~in_pmask;
      hint_q <= hint_in;
      rd_q   <= ld_rd;
      wr_q   <= ld_wr;
    end
  end

  assign valid = valid_q;
  assign match = valid_q && ((q_vpn & ~cur_mask) == tag_q);
  assign q_pfn = pfn_q | PFN_W'(q_vpn & cur_mask);
  assign rd_ok = rd_q;
  assign wr_ok = wr_q;
endmodule

// File: rtl/vtlb_victim.sv
module vtlb_victim #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] vld,
  input  logic         alloc,
  output logic [N-1:0] pick
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] rr_q;
  logic [IW-1:0] idx;
  logic          found;

  always_comb begin
    found = 1'b0;
    idx   = rr_q;
    for (int i = 0; i < N; i++) begin
      if (!vld[i] && !found) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  assign pick = alloc ? (N'(1) << idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (alloc && !found)
      rr_q <= (rr_q == IW'(N-1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/vtlb.sv
module vtlb import vtlb_pkg::*; #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter bit SPLIT   = 1'b0,
  parameter int ENTRIES = 8,
  parameter int SMALL_N = 8,
  parameter int LARGE_N = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inval_all,
  input  logic                  sp_mode,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_va,
  input  logic                  lk_write,
  input  logic                  fill_valid,
  output logic                  fill_ready,
  input  logic [VA_W-OFS_W-1:0] fill_vpn,
  input  logic [PA_W-OFS_W-1:0] fill_pfn,
  input  logic [1:0]            fill_hint,
  input  logic                  fill_rd,
  input  logic                  fill_wr,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_fault,
  output logic [PA_W-1:0]       rsp_pa,
  output logic [1:0]            rsp_prot
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PFN_W = PA_W - OFS_W;
  localparam int TOTAL = SPLIT ? (SMALL_N + LARGE_N) : ENTRIES;

  logic             fill_fire;
  logic [TOTAL-1:0] e_valid, e_match, e_rd, e_wr, e_load;
  logic [PFN_W-1:0] e_pfn [TOTAL];
  logic [VPN_W-1:0] q_vpn;

  assign fill_ready = !inval_all;
  assign fill_fire  = fill_valid && fill_ready;
  assign q_vpn      = lk_va[VA_W-1:OFS_W];

  generate
    if (SPLIT) begin : g_split
      vtlb_victim #(.N(SMALL_N)) u_vic_small (
        .clk(clk), .rst_n(rst_n),
        .vld(e_valid[SMALL_N-1:0]),
        .alloc(fill_fire && (fill_hint == GH_X1)),
        .pick(e_load[SMALL_N-1:0])
      );
      vtlb_victim #(.N(LARGE_N)) u_vic_large (
        .clk(clk), .rst_n(rst_n),
        .vld(e_valid[TOTAL-1:SMALL_N]),
        .alloc(fill_fire && (fill_hint != GH_X1)),
        .pick(e_load[TOTAL-1:SMALL_N])
      );
    end else begin : g_unified
      vtlb_victim #(.N(TOTAL)) u_vic (
        .clk(clk), .rst_n(rst_n),
        .vld(e_valid), .alloc(fill_fire), .pick(e_load)
      );
    end

    for (genvar i = 0; i < TOTAL; i++) begin : g_slot
      vtlb_slot #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .PIN_HINT(SPLIT),
        .PIN_VAL((i < SMALL_N) ? 2'd0 : 2'd3)
      ) u_slot (
        .clk(clk), .rst_n(rst_n), .inval(inval_all), .load(e_load[i]),
        .ld_vpn(fill_vpn), .ld_pfn(fill_pfn), .ld_hint(fill_hint),
        .ld_rd(fill_rd), .ld_wr(fill_wr), .q_vpn(q_vpn),
        .valid(e_valid[i]), .match(e_match[i]), .q_pfn(e_pfn[i]),
        .rd_ok(e_rd[i]), .wr_ok(e_wr[i])
      );
    end
  endgenerate

  // lowest-numbered matching entry answers
  logic             any_m, rd_s, wr_s;
  logic [PFN_W-1:0] pfn_s;
  always_comb begin
    any_m = 1'b0;
    rd_s  = 1'b0;
    wr_s  = 1'b0;
    pfn_s = '0;
    for (int i = 0; i < TOTAL; i++) begin
      if (e_match[i] && !any_m) begin
        any_m = 1'b1;
        pfn_s = e_pfn[i];
        rd_s  = e_rd[i];
        wr_s  = e_wr[i];
      end
    end
  end

  logic            n_hit, n_fault;
  logic [PA_W-1:0] n_pa;
  logic [1:0]      n_prot;
  always_comb begin
    n_hit   = 1'b0;
    n_fault = 1'b0;
    n_pa    = '0;
    n_prot  = 2'b00;
    if (lk_valid) begin
      if (sp_mode) begin
        n_hit  = 1'b1;
        n_pa   = lk_va[PA_W-1:0];
        n_prot = 2'b11;
      end else if (any_m && !inval_all) begin
        n_prot = {wr_s, rd_s};
        if (lk_write ? wr_s : rd_s) begin
          n_hit = 1'b1;
          n_pa  = {pfn_s, lk_va[OFS_W-1:0]};
        end else begin
          n_fault = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_prot  <= 2'b00;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= n_hit;
      rsp_fault <= n_fault;
      rsp_pa    <= n_pa;
      rsp_prot  <= n_prot;
    end
  end
endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inval_all,
  input logic            sp_mode,
  input logic            lk_valid,
  input logic [PA_W-1:0] lk_va_lo,
  input logic            fill_ready,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_pa,
  input logic [1:0]      rsp_prot
);
  a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault && rsp_pa == '0 && rsp_prot == 2'b00));

  a_r6_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  a_r6_fault_lacks_perm: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_prot != 2'b11 && rsp_pa == '0));

  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_pa[12:0] == $past(lk_va_lo[12:0])));

  a_r8_inval_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !sp_mode && inval_all) |=> (!rsp_hit && !rsp_fault));

  a_r8_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |-> !fill_ready);

  a_r9_superpage: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && sp_mode) |=> (rsp_hit && rsp_prot == 2'b11 && rsp_pa == $past(lk_va_lo)));
endmodule

bind vtlb vtlb_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inval_all(inval_all), .sp_mode(sp_mode),
  .lk_valid(lk_valid), .lk_va_lo(lk_va[PA_W-1:0]), .fill_ready(fill_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .rsp_pa(rsp_pa), .rsp_prot(rsp_prot)
);

// File: tb/vtlb_test.sv
module vtlb_test;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inval_all = 0, sp_mode = 0, lk_valid = 0, lk_write = 0;
  logic [31:0] lk_va = '0;
  logic        fill_valid = 0, fill_rd = 0, fill_wr = 0;
  logic [18:0] fill_vpn = '0;
  logic [16:0] fill_pfn = '0;
  logic [1:0]  fill_hint = '0;
  logic        fill_ready, rsp_valid, rsp_hit, rsp_fault;
  logic [29:0] rsp_pa;
  logic [1:0]  rsp_prot;

  logic        s_lk_valid = 0, s_fill_valid = 0;
  logic [31:0] s_lk_va = '0;
  logic [18:0] s_fill_vpn = '0;
  logic [16:0] s_fill_pfn = '0;
  logic [1:0]  s_fill_hint = '0;
  logic        s_fill_ready, s_valid, s_hit, s_fault;
  logic [29:0] s_pa;
  logic [1:0]  s_prot;

  int checks = 0, bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  vtlb uut (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all), .sp_mode(sp_mode),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_hint(fill_hint), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .rsp_prot(rsp_prot)
  );

  vtlb #(.SPLIT(1'b1)) uut_split (
    .clk(clk), .rst_n(rst_n), .inval_all(1'b0), .sp_mode(1'b0),
    .lk_valid(s_lk_valid), .lk_va(s_lk_va), .lk_write(1'b0),
    .fill_valid(s_fill_valid), .fill_ready(s_fill_ready), .fill_vpn(s_fill_vpn),
    .fill_pfn(s_fill_pfn), .fill_hint(s_fill_hint), .fill_rd(1'b1), .fill_wr(1'b1),
    .rsp_valid(s_valid), .rsp_hit(s_hit), .rsp_fault(s_fault),
    .rsp_pa(s_pa), .rsp_prot(s_prot)
  );

  // behavioural model of the unified array
  logic        m_v [NE];
  logic [18:0] m_tag [NE];
  logic [16:0] m_pfn [NE];
  logic [1:0]  m_h [NE];
  logic        m_rd [NE], m_wr [NE];
  int          m_rr = 0;
  logic        e_valid = 0, e_hit = 0, e_fault = 0;
  logic [29:0] e_pa = '0;
  logic [1:0]  e_prot = '0;

  task automatic compare();
    checks++;
    if ({rsp_valid, rsp_hit, rsp_fault, rsp_pa, rsp_prot} !==
        {e_valid, e_hit, e_fault, e_pa, e_prot}) begin
      bad++;
      $display("FAIL %s: got v=%0b h=%0b f=%0b pa=%h prot=%b exp v=%0b h=%0b f=%0b pa=%h prot=%b",
               cur_req, rsp_valid, rsp_hit, rsp_fault, rsp_pa, rsp_prot,
               e_valid, e_hit, e_fault, e_pa, e_prot);
    end
  endtask

  task automatic step(input logic lv, input logic [31:0] va, input logic lw,
                      input logic sp, input logic inv, input logic fv,
                      input logic [18:0] fvpn, input logic [16:0] fpfn,
                      input logic [1:0] fh, input logic frd, input logic fwr);
    logic [18:0] vpn, lm;
    int sel, slot;
    @(negedge clk);
    compare();
    lk_valid = lv; lk_va = va; lk_write = lw; sp_mode = sp; inval_all = inv;
    fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_hint = fh;
    fill_rd = frd; fill_wr = fwr;
    vpn = va[31:13];
    e_valid = lv; e_hit = 0; e_fault = 0; e_pa = '0; e_prot = 2'b00;
    if (lv) begin
      if (sp) begin
        e_hit = 1; e_pa = va[29:0]; e_prot = 2'b11;
      end else if (!inv) begin
        sel = -1;
        for (int i = 0; i < NE; i++) begin
          lm = (19'(1) << (3 * m_h[i])) - 19'(1);
          if (sel < 0 && m_v[i] && ((vpn & ~lm) == m_tag[i])) sel = i;
        end
        if (sel >= 0) begin
          lm = (19'(1) << (3 * m_h[sel])) - 19'(1);
          e_prot = {m_wr[sel], m_rd[sel]};
          if (lw ? m_wr[sel] : m_rd[sel]) begin
            e_hit = 1;
            e_pa = {m_pfn[sel] | 17'(vpn & lm), va[12:0]};
          end else e_fault = 1;
        end
      end
    end
    if (inv) begin
      for (int i = 0; i < NE; i++) m_v[i] = 0;
    end else if (fv) begin
      slot = -1;
      for (int i = 0; i < NE; i++) if (slot < 0 && !m_v[i]) slot = i;
      if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % NE; end
      lm = (19'(1) << (3 * fh)) - 19'(1);
      m_v[slot] = 1; m_tag[slot] = fvpn & ~lm;
      m_pfn[slot] = fpfn & ~17'(lm); m_h[slot] = fh;
      m_rd[slot] = frd; m_wr[slot] = fwr;
    end
  endtask

  task automatic look(input logic [18:0] vpn, input logic [12:0] ofs, input logic lw);
    step(1, {vpn, ofs}, lw, 0, 0, 0, '0, '0, '0, 0, 0);
  endtask
  task automatic fill(input logic [18:0] vpn, input logic [16:0] pfn, input logic [1:0] h,
                      input logic rd, input logic wr);
    step(0, '0, 0, 0, 0, 1, vpn, pfn, h, rd, wr);
  endtask

  // split-instance directed helpers
  task automatic s_fill(input logic [18:0] vpn, input logic [16:0] pfn, input logic [1:0] h);
    @(negedge clk);
    s_fill_valid = 1; s_fill_vpn = vpn; s_fill_pfn = pfn; s_fill_hint = h;
    @(negedge clk);
    s_fill_valid = 0;
  endtask
  task automatic s_look(input logic [18:0] vpn, input logic ex_hit, input logic [16:0] ex_pfn);
    @(negedge clk);
    s_lk_valid = 1; s_lk_va = {vpn, 13'h0a5};
    @(negedge clk);
    s_lk_valid = 0;
    checks++;
    if (s_hit !== ex_hit || (ex_hit && s_pa !== {ex_pfn, 13'h0a5})) begin
      bad++;
      $display("FAIL R10: vpn=%h got hit=%0b pa=%h exp hit=%0b pa=%h",
               vpn, s_hit, s_pa, ex_hit, {ex_pfn, 13'h0a5});
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) m_v[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state and empty-array misses
    cur_req = "R1";
    step(0, '0, 0, 0, 0, 0, '0, '0, '0, 0, 0);
    look(19'h00123, 13'h0, 0);
    look(19'h00000, 13'h0, 1);
    // R2: exact match at hint 0, offset pass-through
    cur_req = "R2";
    fill(19'h00123, 17'h00456, 2'd0, 1, 1);
    look(19'h00123, 13'h1abc, 0);
    look(19'h00124, 13'h1abc, 0);
    look(19'h00122, 13'h0001, 1);
    // R3: group sizes 8, 64, 512 pages
    cur_req = "R3";
    fill(19'h04000, 17'h01000, 2'd1, 1, 1);
    fill(19'h08000, 17'h02000, 2'd2, 1, 1);
    fill(19'h10000, 17'h04000, 2'd3, 1, 1);
    look(19'h04005, 13'h0777, 0);
    look(19'h04008, 13'h0777, 0);
    look(19'h0803f, 13'h1fff, 1);
    look(19'h08040, 13'h0000, 0);
    look(19'h101ff, 13'h0123, 0);
    look(19'h10200, 13'h0123, 0);
    // R4: low bits given on a fill are dropped
    cur_req = "R4";
    fill(19'h20007, 17'h00abf, 2'd1, 1, 1);
    look(19'h20002, 13'h0010, 0);
    look(19'h20000, 13'h0010, 0);
    // R6: permissions
    cur_req = "R6";
    fill(19'h30000, 17'h00300, 2'd0, 1, 0);
    fill(19'h30001, 17'h00301, 2'd0, 0, 1);
    look(19'h30000, 13'h0004, 0);
    look(19'h30000, 13'h0004, 1);
    look(19'h30001, 13'h0008, 0);
    look(19'h30001, 13'h0008, 1);
    // R7: fill the last free slot, then replace round-robin
    cur_req = "R7";
    fill(19'h40000, 17'h00400, 2'd0, 1, 1);
    fill(19'h50000, 17'h00500, 2'd0, 1, 1);
    look(19'h00123, 13'h0, 0);
    look(19'h50000, 13'h0, 0);
    fill(19'h51000, 17'h00510, 2'd0, 1, 1);
    look(19'h04000, 13'h0, 0);
    look(19'h0803f, 13'h0, 0);
    // R8: invalidate with same-cycle lookup and fill
    cur_req = "R8";
    step(1, {19'h101ff, 13'h0}, 0, 0, 1, 1, 19'h60000, 17'h00600, 2'd0, 1, 1);
    #1;
    checks++;
    if (fill_ready !== 1'b0) begin
      bad++;
      $display("FAIL R8: fill_ready got %0b exp 0", fill_ready);
    end
    look(19'h101ff, 13'h0, 0);
    look(19'h60000, 13'h0, 0);
    // R9: superpage mode, also during invalidate
    cur_req = "R9";
    step(1, 32'hfedc_ba98, 1, 1, 0, 0, '0, '0, '0, 0, 0);
    step(1, 32'h1234_5678, 0, 1, 1, 0, '0, '0, '0, 0, 0);
    // R5: mixed random traffic against the model
    cur_req = "R5";
    for (int n = 0; n < 4000; n++) begin
      logic [18:0] v, fvp;
      v   = 19'({3'($urandom), 9'($urandom)});
      fvp = 19'({3'($urandom), 9'($urandom)});
      step(($urandom % 3) != 0, {v, 13'($urandom)}, 1'($urandom),
           ($urandom % 10) == 0, ($urandom % 40) == 0, ($urandom % 4) == 0,
           fvp, 17'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end
    step(0, '0, 0, 0, 0, 0, '0, '0, '0, 0, 0);
    step(0, '0, 0, 0, 0, 0, '0, '0, '0, 0, 0);
    // R10: split configuration
    cur_req = "R10";
    s_fill(19'h00100, 17'h00200, 2'd1);
    s_look(19'h001ff, 1, 17'h003ff);
    for (int k = 0; k < 8; k++) s_fill(19'h40000 + 19'(k), 17'(k), 2'd0);
    s_look(19'h40000, 1, 17'h00000);
    s_fill(19'h50000, 17'h00050, 2'd0);
    s_look(19'h40000, 0, '0);
    s_look(19'h50000, 1, 17'h00050);
    s_look(19'h001ff, 1, 17'h003ff);
    for (int k = 0; k < 4; k++) s_fill(19'h60000 + 19'(k * 512), 17'h00800 + 17'(k * 512), 2'd2);
    s_look(19'h001ff, 0, '0);
    s_look(19'h60401, 1, 17'h00c01);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule